// File: doc/BRIEF.md
# USB Endpoint Byte-Count and Arming Controller

This block holds the byte counts for three USB device endpoints and decides, on behalf of the serial engine, whether each token is answered with data, an ACK or a NAK. Endpoint 0 is bidirectional and keeps a single count register for both directions. Endpoint 1 only receives (OUT). Endpoint 2 only transmits (IN). The packet buffers, CRC checking and token decoding sit outside this block.

The CPU loads a packet into an IN buffer and then writes its length to the endpoint's count register. That write arms the endpoint. The next IN request gets data, and the host's ACK of that packet disarms the endpoint. When an OUT packet arrives, the serial engine reports success together with the received length. If the endpoint's data-available flag is clear, the block ACKs the packet, stores the length and sets the flag. The CPU reads the count, then clears the flag by writing a one to it. One registered interrupt line combines the flags, each gated by its own enable bit.

Top module: `usb_ep_count_arm`

## Requirements
- R1: After reset, every count register, the armed outputs, the data-available outputs, the length-error bit, the enable bits and `irq` are all zero.
- R2: Reads are combinational while `bus_rd` is high. Address 0x0B returns the endpoint 0 count, 0x0C the endpoint 1 count and 0x0D the endpoint 2 count, each with bit 7 as zero. Address 0x0E returns the flag register: bit 0 is endpoint 0 data-available, bit 1 is endpoint 1 data-available, bit 7 is the length error, and the other bits are zero. Address 0x0F returns the enable bits in bits 1:0 (bit 0 for endpoint 0, bit 1 for endpoint 1). Every other address, and any cycle with `bus_rd` low, returns zero.
- R3: A CPU write of a value from 0 to 64 to 0x0B or 0x0D stores that value. From the next cycle, the matching armed bit is high: `armed[0]` for endpoint 0, `armed[1]` for endpoint 2.
- R4: A CPU write of a value above 64 (all 8 data bits compared) to 0x0B or 0x0D stores 64, still arms the endpoint, and sets the sticky length-error bit. Writing 0x0E with bit 7 set clears the error bit.
- R5: In the same cycle as a request, `in_req[i]` gives `in_data[i]` if endpoint i is armed and `in_nak[i]` if it is not. Index 0 is endpoint 0 and index 1 is endpoint 2.
- R6: A pulse on `in_done[i]` clears `armed[i]` on the next cycle. If a CPU write to that endpoint's count lands in the same cycle, the endpoint stays armed.
- R7: `out_ok[i]` with data-available i clear gives `out_ack[i]` in the same cycle. On the next cycle, the count register holds `out_cnt` and `dav[i]` is high. Index 0 is endpoint 0 and index 1 is endpoint 1.
- R8: `out_ok[i]` while `dav[i]` is already high gives `out_nak[i]`, and the count register keeps its value.
- R9: Writing 0x0E clears each data-available flag whose bit (0 or 1) is one. Bits written as zero leave their flag unchanged.
- R10: `irq` is high one cycle after any data-available flag and its enable bit are both set, and it falls one cycle after no such pair remains.
- R11: CPU writes to 0x0C are ignored.
- R12: An endpoint 0 OUT success in the same cycle as a CPU write to 0x0B is NAKed. The CPU value is stored, the endpoint is armed, and `dav[0]` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| in_req | input | 2 | IN token request: [0] endpoint 0, [1] endpoint 2 |
| in_done | input | 2 | Host ACK of the IN packet, same indexing |
| in_data | output | 2 | Answer IN with data |
| in_nak | output | 2 | Answer IN with NAK |
| out_ok | input | 2 | OUT packet received without error: [0] endpoint 0, [1] endpoint 1 |
| out_cnt | input | 7 | Received byte count that goes with `out_ok` |
| out_ack | output | 2 | ACK the OUT packet |
| out_nak | output | 2 | NAK the OUT packet |
| armed | output | 2 | IN endpoint armed: [0] endpoint 0, [1] endpoint 2 |
| dav | output | 2 | Data available: [0] endpoint 0, [1] endpoint 1 |
| irq | output | 1 | Registered interrupt |

## Verification
The assertions assume the serial engine never reports an OUT length above 64. They also assume `in_done` only follows a packet that was actually sent, although the arming logic stays safe if it does not. The stimulus keeps every `out_cnt` in the range 0 to 64. It pulses `out_ok` and `in_done` one at a time, except where R6 and R12 need collisions, and those collisions involve only a CPU write. CPU writes, by contrast, sweep the whole 8-bit value range, so the clamp is checked against every illegal length.

// File: rtl/usb_epc_pkg.sv
// Package: shared constants and helpers for the endpoint byte-count block.
// Assumes: maximum packet length fits in CNT_W bits.
package usb_epc_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 7;
    localparam int MAX_PKT = 64;

    localparam logic [ADDR_W-1:0] A_EP0_CNT = 5'h0B;
    localparam logic [ADDR_W-1:0] A_EP1_CNT = 5'h0C;
    localparam logic [ADDR_W-1:0] A_EP2_CNT = 5'h0D;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 5'h0E;
    localparam logic [ADDR_W-1:0] A_IEN     = 5'h0F;

    // Bit position of the sticky length error in the flag register.
    localparam int ERR_BIT = DATA_W - 1;
endpackage

// File: rtl/epc_count_reg.sv
// Module: one byte-count register.
// A CPU write stores the value, clamped to MAX_PKT, and flags an oversize value.
// A hardware load stores a received length. The CPU write takes priority.
// Assumes: hw_cnt never exceeds MAX_PKT.
module epc_count_reg #(
    parameter int DW      = 8,
    parameter int CNT_W   = 7,
    parameter int MAX_PKT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             hw_ld,
    input  logic [CNT_W-1:0] hw_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             len_err
);
    localparam logic [DW-1:0]    LIM_W = DW'(MAX_PKT);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(MAX_PKT);

    logic             oversize;
    logic [CNT_W-1:0] wr_val;

    // Clamp the CPU value and report an illegal length.
    always_comb begin
        oversize = cpu_wdata > LIM_W;
        wr_val   = oversize ? LIM_C : cpu_wdata[CNT_W-1:0];
        len_err  = cpu_wr && oversize;
    end

    // Count storage: the CPU write wins over the hardware load.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cpu_wr) cnt <= wr_val;
        else if (hw_ld)  cnt <= hw_cnt;
    end

    // R4: a stored count never exceeds the maximum packet length.
    a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_C);
    // R7: a hardware load with no CPU write lands in the register.
    a_r7_hw_load: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ld && !cpu_wr |=> cnt == $past(hw_cnt));
endmodule

// File: rtl/epc_arm.sv
// Module: armed flag of one IN endpoint.
// Set by a CPU count write, cleared by the host ACK of the IN packet.
// Assumes: when both happen in one cycle, the new write re-arms the endpoint.
module epc_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic done,
    output logic armed
);
    // Arm state: arm wins over done.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (arm)  armed <= 1'b1;
        else if (done) armed <= 1'b0;
    end

    a_r3_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> armed);
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done && !arm |=> !armed);
endmodule

// File: rtl/epc_dav.sv
// Module: data-available flag of one OUT endpoint.
// Set by an ACKed OUT packet and cleared when the CPU writes a one to it.
// Assumes: set is only raised while the flag is clear.
module epc_dav (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag state: a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    a_r7_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set |=> !flag);
    a_r8_no_set_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> !set);
endmodule

// File: rtl/usb_ep_count_arm.sv
// Module: CPU-visible byte-count and arming logic for three USB endpoints.
// Endpoint 0 is bidirectional with one shared count register, endpoint 1 is
// OUT only and endpoint 2 is IN only. Decodes the register bus, answers IN and
// OUT tokens and drives a registered interrupt.
// Assumes: out_cnt <= MAX_PKT whenever out_ok is high.
module usb_ep_count_arm
    import usb_epc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        in_req,
    input  logic [1:0]        in_done,
    output logic [1:0]        in_data,
    output logic [1:0]        in_nak,
    input  logic [1:0]        out_ok,
    input  logic [CNT_W-1:0]  out_cnt,
    output logic [1:0]        out_ack,
    output logic [1:0]        out_nak,
    output logic [1:0]        armed,
    output logic [1:0]        dav,
    output logic              irq
);
    localparam int N_IN  = 2;
    localparam int N_OUT = 2;
    localparam int PAD_W = DATA_W - CNT_W;

    logic                 wr_ep0, wr_ep2, wr_flags, wr_ien;
    logic [CNT_W-1:0]     cnt0, cnt1, cnt2;
    logic [1:0]           len_err;
    logic                 err_q;
    logic [N_OUT-1:0]     ien_q;
    logic [N_IN-1:0]      arm_req;
    logic [N_OUT-1:0]     dav_clr;
    logic                 irq_q;

    // Write strobe decode.
    always_comb begin
        wr_ep0   = bus_wr && (bus_addr == A_EP0_CNT);
        wr_ep2   = bus_wr && (bus_addr == A_EP2_CNT);
        wr_flags = bus_wr && (bus_addr == A_FLAGS);
        wr_ien   = bus_wr && (bus_addr == A_IEN);
        arm_req  = {wr_ep2, wr_ep0};
        dav_clr  = {N_OUT{wr_flags}} & bus_wdata[N_OUT-1:0];
    end

    // OUT handshake: ACK only into an empty endpoint not being written by the CPU.
    always_comb begin
        out_ack[0] = out_ok[0] && !dav[0] && !wr_ep0;
        out_ack[1] = out_ok[1] && !dav[1];
        out_nak    = out_ok & ~out_ack;
    end

    // IN handshake: data when armed, NAK otherwise.
    always_comb begin
        in_data = in_req & armed;
        in_nak  = in_req & ~armed;
    end

    epc_count_reg #(.DW(DATA_W), .CNT_W(CNT_W), .MAX_PKT(MAX_PKT)) u_cnt0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(wr_ep0), .cpu_wdata(bus_wdata),
        .hw_ld(out_ack[0]), .hw_cnt(out_cnt), .cnt(cnt0), .len_err(len_err[0]));

    epc_count_reg #(.DW(DATA_W), .CNT_W(CNT_W), .MAX_PKT(MAX_PKT)) u_cnt1 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(1'b0), .cpu_wdata(bus_wdata),
        .hw_ld(out_ack[1]), .hw_cnt(out_cnt), .cnt(cnt1), .len_err());

    epc_count_reg #(.DW(DATA_W), .CNT_W(CNT_W), .MAX_PKT(MAX_PKT)) u_cnt2 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(wr_ep2), .cpu_wdata(bus_wdata),
        .hw_ld(1'b0), .hw_cnt(out_cnt), .cnt(cnt2), .len_err(len_err[1]));

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_arm
        epc_arm u_arm (.clk(clk), .rst_n(rst_n), .arm(arm_req[gi]),
                       .done(in_done[gi]), .armed(armed[gi]));
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_dav
        epc_dav u_dav (.clk(clk), .rst_n(rst_n), .set(out_ack[go]),
                       .clr(dav_clr[go]), .flag(dav[go]));
    end

    // Sticky length error: a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                              err_q <= 1'b0;
        else if (|len_err)                       err_q <= 1'b1;
        else if (wr_flags && bus_wdata[ERR_BIT]) err_q <= 1'b0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= bus_wdata[N_OUT-1:0];
    end

    // Registered interrupt from enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(dav & ien_q);
    end
    assign irq = irq_q;

    // Read multiplexer; unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_EP0_CNT: bus_rdata = {{PAD_W{1'b0}}, cnt0};
                A_EP1_CNT: bus_rdata = {{PAD_W{1'b0}}, cnt1};
                A_EP2_CNT: bus_rdata = {{PAD_W{1'b0}}, cnt2};
                A_FLAGS: begin
                    bus_rdata[N_OUT-1:0] = dav;
                    bus_rdata[ERR_BIT]   = err_q;
                end
                A_IEN:     bus_rdata[N_OUT-1:0] = ien_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R8: a NAKed OUT leaves the endpoint 0 count alone.
    a_r8_ep0_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok[0] && dav[0] && !wr_ep0 |=> $stable(cnt0));
    // R11: endpoint 1 count moves only on an ACKed OUT.
    a_r11_ep1_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ack[1] |=> $stable(cnt1));
    // R10: an interrupt never rises without a pending flag.
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dav != 2'b00));
    // R12: a CPU write to endpoint 0 blocks the OUT ACK in that cycle.
    a_r12_cpu_beats_out: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ep0 |-> !out_ack[0]);
    // R5: an IN request is answered exactly once.
    a_r5_in_answered: assert property (@(posedge clk) disable iff (!rst_n)
        in_req[0] |-> $countones({in_data[0], in_nak[0]}) == 1);
endmodule

// File: tb/test_usb_ep_count_arm.sv
// Bench: sweeps CPU write values and OUT lengths, and checks arming,
// handshakes, flags and the interrupt against values computed here.
module test_usb_ep_count_arm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] in_req = '0, in_done = '0, out_ok = '0;
    logic [6:0] out_cnt = '0;
    logic [1:0] in_data, in_nak, out_ack, out_nak, armed, dav;
    logic       irq;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    usb_ep_count_arm i_usb_ep_count_arm (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_req(in_req), .in_done(in_done), .in_data(in_data), .in_nak(in_nak),
        .out_ok(out_ok), .out_cnt(out_cnt), .out_ack(out_ack), .out_nak(out_nak),
        .armed(armed), .dav(dav), .irq(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic out_pkt(input int ep, input int n, input bit exp_ack, input string tag);
        @(negedge clk);
        out_ok[ep] = 1'b1; out_cnt = 7'(n);
        #1 chk(tag, {out_ack[ep], out_nak[ep]}, exp_ack ? 2'b10 : 2'b01);
        @(negedge clk);
        out_ok = '0;
    endtask

    task automatic host_ack(input int idx);
        @(negedge clk);
        in_done[idx] = 1'b1;
        @(negedge clk);
        in_done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 armed", armed, 0);
        chk("R1 dav", dav, 0);
        chk("R1 irq", irq, 0);
        for (int a = 11; a <= 15; a++) begin
            rd(5'(a), d); chk("R1 reg", d, 0);
        end

        // R2 address map sweep, with bus_rd low as well
        wr(5'h0B, 8'd33); wr(5'h0D, 8'd64); wr(5'h0F, 8'h03);
        for (int a = 0; a < 32; a++) begin
            case (a)
                11: exp = 33;
                13: exp = 64;
                15: exp = 3;
                default: exp = 0;
            endcase
            rd(5'(a), d); chk("R2 map", d, exp);
        end
        bus_addr = 5'h0B; #1 chk("R2 rd low", bus_rdata, 0);
        wr(5'h0F, 8'h00); host_ack(0); host_ack(1);

        // R3/R4/R6 full sweep of written values on both IN endpoints
        for (int ep = 0; ep < 2; ep++) begin
            for (int v = 0; v < 256; v++) begin
                logic [4:0] a;
                a = (ep == 0) ? 5'h0B : 5'h0D;
                wr(a, 8'(v));
                chk("R3 armed", armed[ep], 1);
                rd(a, d); chk("R4 clamp", d, (v > 64) ? 64 : v);
                rd(5'h0E, d); chk("R4 err", d[7], (v > 64) ? 1 : 0);
                if (v > 64) begin
                    wr(5'h0E, 8'h80);
                    rd(5'h0E, d); chk("R4 err clear", d[7], 0);
                end
                host_ack(ep);
                chk("R6 disarm", armed[ep], 0);
            end
        end

        // R5 IN answers
        @(negedge clk); in_req = 2'b11;
        #1 chk("R5 nak unarmed", {in_data, in_nak}, 4'b0011);
        in_req = '0;
        wr(5'h0D, 8'd10);
        @(negedge clk); in_req = 2'b11;
        #1 chk("R5 mixed", {in_data, in_nak}, 4'b1001);
        in_req = '0;

        // R6 re-arm collides with host ACK
        @(negedge clk);
        bus_addr = 5'h0D; bus_wdata = 8'd5; bus_wr = 1'b1; in_done[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; in_done = '0;
        chk("R6 rearm wins", armed[1], 1);
        host_ack(1);

        // R7/R8/R9/R11 sweep of OUT lengths on endpoint 1
        for (int c = 0; c <= 64; c++) begin
            out_pkt(1, c, 1, "R7 ack");
            chk("R7 dav", dav[1], 1);
            rd(5'h0C, d); chk("R7 count", d, c);
            out_pkt(1, (c + 7) % 65, 0, "R8 nak");
            rd(5'h0C, d); chk("R8 count kept", d, c);
            wr(5'h0C, 8'd50);
            rd(5'h0C, d); chk("R11 ignored", d, c);
            wr(5'h0E, 8'h00);
            chk("R9 zero no effect", dav[1], 1);
            wr(5'h0E, 8'h02);
            chk("R9 cleared", dav[1], 0);
        end

        // R7/R8 endpoint 0 OUT
        out_pkt(0, 40, 1, "R7 ep0 ack");
        rd(5'h0B, d); chk("R7 ep0 count", d, 40);
        chk("R7 ep0 dav", dav[0], 1);
        out_pkt(0, 3, 0, "R8 ep0 nak");
        rd(5'h0B, d); chk("R8 ep0 kept", d, 40);
        wr(5'h0E, 8'h01);
        chk("R9 ep0 cleared", dav[0], 0);

        // R10 interrupt timing and gating
        out_pkt(1, 9, 1, "R10 setup");
        @(negedge clk); chk("R10 disabled", irq, 0);
        wr(5'h0F, 8'h01);
        @(negedge clk); chk("R10 other enable", irq, 0);
        wr(5'h0F, 8'h02);
        chk("R10 one cycle late", irq, 0);
        @(negedge clk); chk("R10 raised", irq, 1);
        wr(5'h0E, 8'h02);
        chk("R10 still high", irq, 1);
        @(negedge clk); chk("R10 dropped", irq, 0);
        wr(5'h0F, 8'h00);

        // R12 CPU write collides with endpoint 0 OUT
        @(negedge clk);
        bus_addr = 5'h0B; bus_wdata = 8'd5; bus_wr = 1'b1;
        out_ok[0] = 1'b1; out_cnt = 7'd20;
        #1 chk("R12 nak", {out_ack[0], out_nak[0]}, 2'b01);
        @(negedge clk);
        bus_wr = 1'b0; out_ok = '0;
        rd(5'h0B, d); chk("R12 cpu value", d, 5);
        chk("R12 armed", armed[0], 1);
        chk("R12 no dav", dav[0], 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule